// File: doc/BRIEF.md
# CAM Host Port Cycle Decoder

This block is the host side of a content-addressable memory's 16-bit bus port. Three active-low strobes are sampled on each rising clock edge. The enable strobe says whether a bus cycle takes place. The command/data and write strobes then pick one of four cycle types. For each cycle the block works out which internal resource the transfer belongs to. It then either loads one of its own configuration registers, raises a strobe toward the comparand, mask and array logic outside, or drives read data onto the bus with the output enable raised.

Targets come from several sources:
- a fixed default for each cycle type;
- an address flag that redirects only the next cycle;
- one-shot override instructions, consumed by the next command cycle;
- persistent data source and destination selections, which stay in force until changed.

Command reads of status come in two halves: low half first, then high half. The block also compares a device-select register with a page-address register to decide whether the device takes part in a cycle. A device-select value of all ones makes the device write-only.

Instruction word layout:
- bit 11: address flag.
- bits 10..8: operation. 1 is a one-shot override, 2 selects the persistent source, 3 selects the persistent destination, and any other value has no effect.
- bits 3..0: target code.

Read data and strobes are combinational from the current cycle's inputs and registered state. Register updates take effect at the clock edge that ends the cycle.

Top module: `cam_hostport`

## Requirements
- R1: While en_n is high no cycle takes place. dq_oe, dat_wr and dat_rd stay low, no register changes, and the address flag, pending override and status phase are all kept.
- R2: With en_n low, {cmd_n, wr_n} sets the cycle type: 00 is a command write, 01 a command read, 10 a data write, and 11 a data read. dq_oe may be high only in read cycles, and dat_wr and dat_rd only in data cycles.
- R3: By default a command write loads the instruction word. Bits 10..8 are the operation (1 override, 2 select source, 3 select destination), bit 11 is the address flag, and bits 3..0 are the target.
- R4: A loaded instruction with bit 11 set sends the next enabled cycle, if it is a command write, to the address register. The flag lasts exactly one enabled cycle.
- R5: An override instruction names a target:
  - 0 address, 1 control, 2 page address, 3 segment control, 4 device select;
  - 5 next-free address, which is readable only; a write there is dropped;
  - 6 and 7 read back the words that last set the persistent source and destination.

  The override applies to the next enabled command cycle only. Data cycles in between leave it pending. It takes priority over the address flag.
- R6: By default a command read returns status bits 15..0. A command read that directly follows such a read returns bits 31..16. Any other enabled cycle restarts at bits 15..0.
- R7: A data write raises dat_wr with dat_tgt equal to the persistent destination. A data read raises dat_rd, drives dat_rdata onto dq_out, and sets dat_tgt to the persistent source.
  - Target codes: 0 comparand, 1 mask 1, 2 mask 2, 3 array at address, 4 array at next-free address (destination only), 5 array at match.
  - Both selections reset to 0. A select instruction with a code not allowed for its kind is ignored.
- R8: An override read with target 6 or 7 returns the full instruction word that last set the source or destination. After reset these words are 16'h0200 and 16'h0300.
- R9: Read cycles proceed only when device select equals page address and is not 16'hFFFF. Write cycles proceed when the two are equal or device select is 16'hFFFF. A blocked cycle keeps dq_oe and the strobes low and changes no register.
- R10: Device select can always be written. While deselected, a command write of an override-to-device-select instruction is still accepted, and the following command write loads device select.
- R11: Reset clears address, control and segment registers and all sequencing state, and loads page address and device select both with PAGE_RST so the device starts selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; cycles are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low cycle enable |
| cmd_n | input | 1 | Low for command cycles, high for data cycles |
| wr_n | input | 1 | Low for writes, high for reads |
| dq_in | input | W | Bus write data |
| dq_out | output | W | Bus read data |
| dq_oe | output | 1 | Output enable for the bus driver |
| dat_wr | output | 1 | Data write strobe to the comparand/mask/array logic |
| dat_rd | output | 1 | Data read strobe to the comparand/mask/array logic |
| dat_tgt | output | 3 | Data cycle target code (R7 encoding) |
| dat_rdata | input | W | Read data returned by the selected data resource |
| status_in | input | 2W | Device status word |
| nfa_in | input | W | Next-free address value |
| cfg_addr | output | W | Address register |
| cfg_ctrl | output | W | Control register |
| cfg_page | output | W | Page-address register |
| cfg_seg | output | W | Segment-control register |
| cfg_devsel | output | W | Device-select register |

## Verification
The hardest state to reach is a deselected device. Once device select differs from page address, nearly every cycle is refused. The only way back is the narrow path of an override-to-device-select instruction followed by a write. The stimulus first moves the page-address register away with an override while selected. It then checks that reads, data writes and ordinary override instructions are all refused, and that the control register and outputs stay unchanged. Finally it uses the device-select override to recover, and repeats the sequence with the all-ones write-only setting.

// File: rtl/cam_hostport_pkg.sv
package cam_hostport_pkg;

  // Cycle type is the pair {cmd_n, wr_n} taken while en_n is low.
  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'b00,
    CYC_CMD_RD = 2'b01,
    CYC_DAT_WR = 2'b10,
    CYC_DAT_RD = 2'b11
  } cyc_e;

  // Persistent data source/destination codes.
  typedef enum logic [2:0] {
    DT_CMP     = 3'd0,
    DT_MSK1    = 3'd1,
    DT_MSK2    = 3'd2,
    DT_ARR_ADR = 3'd3,
    DT_ARR_NFA = 3'd4,
    DT_ARR_MAT = 3'd5
  } dtgt_e;

  // Command write targets; the first five index the configuration bank.
  localparam int unsigned CFG_N = 5;
  typedef enum logic [2:0] {
    CFG_ADDR  = 3'd0,
    CFG_CTRL  = 3'd1,
    CFG_PAGE  = 3'd2,
    CFG_SEG   = 3'd3,
    CFG_DSEL  = 3'd4,
    CFG_INSTR = 3'd5,
    CFG_NONE  = 3'd6
  } cwt_e;

  // Command read sources; codes 0..7 equal the override target field.
  typedef enum logic [3:0] {
    CR_ADDR  = 4'd0,
    CR_CTRL  = 4'd1,
    CR_PAGE  = 4'd2,
    CR_SEG   = 4'd3,
    CR_DSEL  = 4'd4,
    CR_NFA   = 4'd5,
    CR_PS    = 4'd6,
    CR_PD    = 4'd7,
    CR_ST_LO = 4'd8,
    CR_ST_HI = 4'd9
  } crs_e;

  // Instruction word fields.
  localparam int unsigned ADR_FLAG_BIT = 11;
  localparam int unsigned OP_LSB       = 8;
  localparam int unsigned OP_W         = 3;
  localparam int unsigned TG_W         = 4;

  localparam logic [OP_W-1:0] OP_OVR = 3'd1;
  localparam logic [OP_W-1:0] OP_SPS = 3'd2;
  localparam logic [OP_W-1:0] OP_SPD = 3'd3;

  localparam logic [TG_W-1:0] OV_DSEL    = 4'd4;
  localparam logic [TG_W-1:0] OV_LAST    = 4'd7;
  localparam logic [TG_W-1:0] DT_LAST    = 4'd5;
  localparam logic [TG_W-1:0] DT_NFA_TG  = 4'd4;

endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_hostport_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         en_n,
  input  logic         cmd_n,
  input  logic         wr_n,
  input  logic [W-1:0] devsel,
  input  logic [W-1:0] page,
  output logic         active,
  output cyc_e         cyc,
  output logic         wr_ok,
  output logic         rd_ok
);

  localparam logic [W-1:0] WRITE_ONLY = '1;

  logic same_page;
  logic wonly;

  assign active    = ~en_n;
  assign cyc       = cyc_e'({cmd_n, wr_n});
  assign same_page = (devsel == page);
  assign wonly     = (devsel == WRITE_ONLY);
  assign wr_ok     = same_page | wonly;
  assign rd_ok     = same_page & ~wonly;

endmodule

// File: rtl/cam_target_ctrl.sv
module cam_target_ctrl
  import cam_hostport_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  cyc_e         cyc,
  input  logic         wr_ok,
  input  logic         rd_ok,
  input  logic [W-1:0] din,
  output logic         cw_go,
  output cwt_e         cw_tgt,
  output logic         cr_go,
  output crs_e         cr_src,
  output logic         dw_go,
  output logic         dr_go,
  output dtgt_e        ps,
  output dtgt_e        pd,
  output logic [W-1:0] ps_word,
  output logic [W-1:0] pd_word
);

  localparam int unsigned PAD = W - OP_LSB - OP_W;
  localparam logic [W-1:0] PS_RST = {{PAD{1'b0}}, OP_SPS, {OP_LSB{1'b0}}};
  localparam logic [W-1:0] PD_RST = {{PAD{1'b0}}, OP_SPD, {OP_LSB{1'b0}}};

  logic            adr_flag;
  logic            ovr_v;
  logic [TG_W-1:0] ovr_t;
  logic            st_hi;

  logic [OP_W-1:0] op;
  logic [TG_W-1:0] tg;
  logic            dsel_ovr_word;
  logic            cmd_cyc;
  logic            ins_load;
  logic            ps_ok;
  logic            pd_ok;

  assign op            = din[OP_LSB +: OP_W];
  assign tg            = din[TG_W-1:0];
  assign dsel_ovr_word = (op == OP_OVR) && (tg == OV_DSEL);
  assign cmd_cyc       = active && ((cyc == CYC_CMD_WR) || (cyc == CYC_CMD_RD));

  // Command write target: override, then address flag, then instruction.
  always_comb begin
    if (ovr_v) begin
      cw_tgt = (ovr_t < TG_W'(CFG_N)) ? cwt_e'(ovr_t[2:0]) : CFG_NONE;
    end else if (adr_flag) begin
      cw_tgt = CFG_ADDR;
    end else begin
      cw_tgt = CFG_INSTR;
    end
  end

  // Command read source: override, then status phase.
  always_comb begin
    if (ovr_v) begin
      cr_src = crs_e'(ovr_t);
    end else if (st_hi) begin
      cr_src = CR_ST_HI;
    end else begin
      cr_src = CR_ST_LO;
    end
  end

  assign cw_go = active && (cyc == CYC_CMD_WR) && (cw_tgt != CFG_NONE) &&
                 (wr_ok || (cw_tgt == CFG_DSEL) ||
                  ((cw_tgt == CFG_INSTR) && dsel_ovr_word));
  assign cr_go = active && (cyc == CYC_CMD_RD) && rd_ok;
  assign dw_go = active && (cyc == CYC_DAT_WR) && wr_ok;
  assign dr_go = active && (cyc == CYC_DAT_RD) && rd_ok;

  assign ins_load = cw_go && (cw_tgt == CFG_INSTR);
  assign ps_ok    = (tg <= DT_LAST) && (tg != DT_NFA_TG);
  assign pd_ok    = (tg <= DT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_flag <= 1'b0;
      ovr_v    <= 1'b0;
      ovr_t    <= '0;
      st_hi    <= 1'b0;
      ps       <= DT_CMP;
      pd       <= DT_CMP;
      ps_word  <= PS_RST;
      pd_word  <= PD_RST;
    end else if (active) begin
      adr_flag <= ins_load && din[ADR_FLAG_BIT];
      st_hi    <= cr_go && (cr_src == CR_ST_LO);
      if (ins_load && (op == OP_OVR) && (tg <= OV_LAST)) begin
        ovr_v <= 1'b1;
        ovr_t <= tg;
      end else if (cmd_cyc) begin
        ovr_v <= 1'b0;
      end
      if (ins_load && (op == OP_SPS) && ps_ok) begin
        ps      <= dtgt_e'(tg[2:0]);
        ps_word <= din;
      end
      if (ins_load && (op == OP_SPD) && pd_ok) begin
        pd      <= dtgt_e'(tg[2:0]);
        pd_word <= din;
      end
    end
  end

endmodule

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs
  import cam_hostport_pkg::*;
#(
  parameter int unsigned    W        = 16,
  parameter logic [W-1:0]   PAGE_RST = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  cwt_e                     sel,
  input  logic [W-1:0]             d,
  output logic [CFG_N-1:0][W-1:0]  q
);

  for (genvar g = 0; g < CFG_N; g++) begin : g_reg
    localparam logic [W-1:0] RST_VAL =
      ((g == int'(CFG_PAGE)) || (g == int'(CFG_DSEL))) ? PAGE_RST : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[g] <= RST_VAL;
      end else if (we && (sel == cwt_e'(g))) begin
        q[g] <= d;
      end
    end
  end

endmodule

// File: rtl/cam_hostport.sv
module cam_hostport
  import cam_hostport_pkg::*;
#(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] PAGE_RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_n,
  input  logic           cmd_n,
  input  logic           wr_n,
  input  logic [W-1:0]   dq_in,
  output logic [W-1:0]   dq_out,
  output logic           dq_oe,
  output logic           dat_wr,
  output logic           dat_rd,
  output logic [2:0]     dat_tgt,
  input  logic [W-1:0]   dat_rdata,
  input  logic [2*W-1:0] status_in,
  input  logic [W-1:0]   nfa_in,
  output logic [W-1:0]   cfg_addr,
  output logic [W-1:0]   cfg_ctrl,
  output logic [W-1:0]   cfg_page,
  output logic [W-1:0]   cfg_seg,
  output logic [W-1:0]   cfg_devsel
);

  logic                    active;
  cyc_e                    cyc;
  logic                    wr_ok;
  logic                    rd_ok;
  logic                    cw_go;
  cwt_e                    cw_tgt;
  logic                    cr_go;
  crs_e                    cr_src;
  logic                    dw_go;
  logic                    dr_go;
  dtgt_e                   ps;
  dtgt_e                   pd;
  logic [W-1:0]            ps_word;
  logic [W-1:0]            pd_word;
  logic [CFG_N-1:0][W-1:0] cfg_q;
  logic                    cfg_we;
  logic [W-1:0]            cmd_rdata;

  cam_cycle_decode #(.W(W)) u_dec (
    .en_n   (en_n),
    .cmd_n  (cmd_n),
    .wr_n   (wr_n),
    .devsel (cfg_q[CFG_DSEL]),
    .page   (cfg_q[CFG_PAGE]),
    .active (active),
    .cyc    (cyc),
    .wr_ok  (wr_ok),
    .rd_ok  (rd_ok)
  );

  cam_target_ctrl #(.W(W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .cyc     (cyc),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .din     (dq_in),
    .cw_go   (cw_go),
    .cw_tgt  (cw_tgt),
    .cr_go   (cr_go),
    .cr_src  (cr_src),
    .dw_go   (dw_go),
    .dr_go   (dr_go),
    .ps      (ps),
    .pd      (pd),
    .ps_word (ps_word),
    .pd_word (pd_word)
  );

  assign cfg_we = cw_go && (cw_tgt != CFG_INSTR);

  cam_cfg_regs #(.W(W), .PAGE_RST(PAGE_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cw_tgt),
    .d     (dq_in),
    .q     (cfg_q)
  );

  always_comb begin
    case (cr_src)
      CR_ADDR:  cmd_rdata = cfg_q[CFG_ADDR];
      CR_CTRL:  cmd_rdata = cfg_q[CFG_CTRL];
      CR_PAGE:  cmd_rdata = cfg_q[CFG_PAGE];
      CR_SEG:   cmd_rdata = cfg_q[CFG_SEG];
      CR_DSEL:  cmd_rdata = cfg_q[CFG_DSEL];
      CR_NFA:   cmd_rdata = nfa_in;
      CR_PS:    cmd_rdata = ps_word;
      CR_PD:    cmd_rdata = pd_word;
      CR_ST_HI: cmd_rdata = status_in[2*W-1:W];
      default:  cmd_rdata = status_in[W-1:0];
    endcase
  end

  assign dq_oe   = cr_go | dr_go;
  assign dq_out  = cr_go ? cmd_rdata : (dr_go ? dat_rdata : '0);
  assign dat_wr  = dw_go;
  assign dat_rd  = dr_go;
  assign dat_tgt = (cyc == CYC_DAT_WR) ? pd : ps;

  assign cfg_addr   = cfg_q[CFG_ADDR];
  assign cfg_ctrl   = cfg_q[CFG_CTRL];
  assign cfg_page   = cfg_q[CFG_PAGE];
  assign cfg_seg    = cfg_q[CFG_SEG];
  assign cfg_devsel = cfg_q[CFG_DSEL];

endmodule

// File: rtl/cam_hostport_chk.sv
module cam_hostport_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_n,
  input logic         cmd_n,
  input logic         wr_n,
  input logic         dq_oe,
  input logic         dat_wr,
  input logic         dat_rd,
  input logic [W-1:0] cfg_addr,
  input logic [W-1:0] cfg_ctrl,
  input logic [W-1:0] cfg_page,
  input logic [W-1:0] cfg_seg,
  input logic [W-1:0] cfg_devsel
);

  localparam logic [W-1:0] ALL_ONES = '1;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!dq_oe && !dat_wr && !dat_rd)); // R1

  AST_IDLE_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> ($stable(cfg_addr) && $stable(cfg_ctrl) && $stable(cfg_page) &&
              $stable(cfg_seg) && $stable(cfg_devsel))); // R1

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> wr_n); // R2

  AST_DAT_STROBE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr || dat_rd) |-> cmd_n); // R2

  AST_DESEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_devsel != cfg_page) || (cfg_devsel == ALL_ONES)) |-> !dq_oe); // R9

  AST_DESEL_NO_DWR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_devsel != cfg_page) && (cfg_devsel != ALL_ONES)) |-> !dat_wr); // R9

endmodule

bind cam_hostport cam_hostport_chk #(.W(W)) u_chk (.*);

// File: tb/cam_hostport_tb.sv
`timescale 1ns/1ps
module cam_hostport_tb;

  localparam int unsigned W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en_n = 1'b1;
  logic           cmd_n = 1'b1;
  logic           wr_n = 1'b1;
  logic [W-1:0]   dq_in = '0;
  logic [W-1:0]   dq_out;
  logic           dq_oe;
  logic           dat_wr;
  logic           dat_rd;
  logic [2:0]     dat_tgt;
  logic [W-1:0]   dat_rdata = 16'h6789;
  logic [2*W-1:0] status_in = 32'hA5A5_3C3C;
  logic [W-1:0]   nfa_in = 16'h0F0F;
  logic [W-1:0]   cfg_addr, cfg_ctrl, cfg_page, cfg_seg, cfg_devsel;

  int checks = 0;
  int errors = 0;
  logic           s_oe, s_dwr, s_drd;
  logic [W-1:0]   s_dq;
  logic [2:0]     s_tgt;

  always #2.5 clk = ~clk;

  cam_hostport #(.W(W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic e, input logic c, input logic w, input logic [W-1:0] d);
    @(negedge clk);
    en_n = e; cmd_n = c; wr_n = w; dq_in = d;
    #1;
    s_oe = dq_oe; s_dq = dq_out; s_dwr = dat_wr; s_drd = dat_rd; s_tgt = dat_tgt;
    @(posedge clk);
    #1;
    en_n = 1'b1;
  endtask

  task automatic cw(input logic [W-1:0] d); bus(1'b0, 1'b0, 1'b0, d); endtask
  task automatic cr();                      bus(1'b0, 1'b0, 1'b1, '0); endtask
  task automatic dw(input logic [W-1:0] d); bus(1'b0, 1'b1, 1'b0, d); endtask
  task automatic dr();                      bus(1'b0, 1'b1, 1'b1, '0); endtask

  task automatic t_reset();
    chk("R11 addr", cfg_addr, 0);
    chk("R11 ctrl", cfg_ctrl, 0);
    chk("R11 seg", cfg_seg, 0);
    chk("R11 page", cfg_page, 0);
    chk("R11 devsel", cfg_devsel, 0);
    cr();
    chk("R6 first read oe", s_oe, 1);
    chk("R6 first read low half", s_dq, 16'h3C3C);
    cw(16'h0106); cr();
    chk("R8 reset source word", s_dq, 16'h0200);
    cw(16'h0107); cr();
    chk("R8 reset dest word", s_dq, 16'h0300);
  endtask

  task automatic t_idle();
    bus(1'b1, 1'b0, 1'b0, 16'h0101);
    chk("R1 idle write oe", s_oe, 0);
    chk("R1 idle write strobes", {s_dwr, s_drd}, 0);
    bus(1'b1, 1'b1, 1'b1, '0);
    chk("R1 idle read oe", s_oe, 0);
    chk("R1 idle read strobe", s_drd, 0);
    cr();
    chk("R1 no override from idle", s_dq, 16'h3C3C);
    bus(1'b1, 1'b1, 1'b0, '0);
    cr();
    chk("R1 idle keeps status phase", s_dq, 16'hA5A5);
  endtask

  task automatic t_status();
    cr(); chk("R6 restart low", s_dq, 16'h3C3C);
    cr(); chk("R6 high half", s_dq, 16'hA5A5);
    cr(); chk("R6 low after high", s_dq, 16'h3C3C);
    dw(16'h0001);
    chk("R7 default dest strobe", s_dwr, 1);
    chk("R7 default dest comparand", s_tgt, 0);
    cr(); chk("R6 data cycle restarts", s_dq, 16'h3C3C);
  endtask

  task automatic t_addr();
    cw(16'h0800);
    chk("R2 command write no oe", s_oe, 0);
    cw(16'h1234);
    chk("R4 flag loads address", cfg_addr, 16'h1234);
    cw(16'h0055);
    chk("R4 flag one shot", cfg_addr, 16'h1234);
    cw(16'h0800);
    dr();
    chk("R7 default source read data", s_dq, 16'h6789);
    chk("R7 default source code", {s_drd, s_tgt}, {1'b1, 3'd0});
    cw(16'h0055);
    chk("R4 flag expires after other cycle", cfg_addr, 16'h1234);
  endtask

  task automatic t_override();
    cw(16'h0101); cw(16'hBEEF);
    chk("R3 R5 override control", cfg_ctrl, 16'hBEEF);
    cw(16'h0000);
    chk("R5 override consumed", cfg_ctrl, 16'hBEEF);
    cw(16'h0103); dr(); cw(16'h00AA);
    chk("R5 override across data cycle", cfg_seg, 16'h00AA);
    cw(16'h0100); cr();
    chk("R5 override read address", s_dq, 16'h1234);
    cr();
    chk("R5 read override consumed", s_dq, 16'h3C3C);
    cw(16'h0105); cr();
    chk("R5 next-free read", s_dq, 16'h0F0F);
    cw(16'h0105); cw(16'h7777);
    chk("R5 next-free write dropped", {cfg_addr, cfg_ctrl}, {16'h1234, 16'hBEEF});
    chk("R5 next-free write dropped seg", {cfg_seg, cfg_page, cfg_devsel}, {16'h00AA, 32'h0});
    cr();
    chk("R5 dropped write consumed override", s_dq, 16'h3C3C);
    cw(16'h0901); cw(16'h4242);
    chk("R5 override beats flag", {cfg_ctrl, cfg_addr}, {16'h4242, 16'h1234});
  endtask

  task automatic t_persist();
    cw(16'h0201); dr();
    chk("R7 source mask1", {s_drd, s_tgt}, {1'b1, 3'd1});
    cw(16'h0304); dw(16'h0002);
    chk("R7 dest next-free array", {s_dwr, s_tgt}, {1'b1, 3'd4});
    cw(16'h0204); dr();
    chk("R7 invalid source ignored", s_tgt, 3'd1);
    cw(16'h0106); cr();
    chk("R8 source word", s_dq, 16'h0201);
    cw(16'h0107); cr();
    chk("R8 dest word", s_dq, 16'h0304);
    cw(16'h0305); dw(16'h0003);
    chk("R7 dest match array", s_tgt, 3'd5);
  endtask

  task automatic t_devsel();
    cw(16'h0102); cw(16'h0003);
    chk("R9 page moved", cfg_page, 16'h0003);
    cr();
    chk("R9 deselected command read", s_oe, 0);
    dw(16'h0004);
    chk("R9 deselected data write", s_dwr, 0);
    dr();
    chk("R9 deselected data read", {s_oe, s_drd}, 0);
    cw(16'h0101); cw(16'h9999);
    chk("R9 deselected control blocked", cfg_ctrl, 16'h4242);
    cw(16'h0104); cw(16'h0003);
    chk("R10 devsel written while deselected", cfg_devsel, 16'h0003);
    cr();
    chk("R9 reselected read", {s_oe, s_dq}, {1'b1, 16'h3C3C});
    cw(16'h0104); cw(16'hFFFF);
    chk("R10 devsel all ones", cfg_devsel, 16'hFFFF);
    dw(16'h0005);
    chk("R9 write-only data write", s_dwr, 1);
    dr();
    chk("R9 write-only data read", s_oe, 0);
    cr();
    chk("R9 write-only command read", s_oe, 0);
    cw(16'h0101); cw(16'h1111);
    chk("R9 write-only command write", cfg_ctrl, 16'h1111);
    cw(16'h0104); cw(16'h0003); cr();
    chk("R9 restored selection", s_oe, 1);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_idle();
    t_status();
    t_addr();
    t_override();
    t_persist();
    t_devsel();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule